// File: doc/BRIEF.md
# Shift-Add Sequential Binary Multiplier

This block multiplies two unsigned WIDTH-bit operands by shifting and adding. The multiplicand is held in register B and the multiplier in shift register Q. The partial product builds up in accumulator A, with a carry flip-flop C above it. A log2(WIDTH)-bit down-counter, with a zero detector, tracks how many multiplier bits remain. A hardwired controller steps through three states, held as a two-bit binary code and decoded into one-hot state lines.

Each multiplier bit takes two cycles. The first cycle adds B into A when the low bit of Q is set. The second cycle shifts C, A and Q right together by one place and counts the counter down. The counter's zero test is made on its value before the decrement. A full multiplication is therefore WIDTH add/shift pairs, or 2·WIDTH busy cycles.

Operands are written from the shared input bus by two separate load strobes, which work independently of the controller. When the block is back in idle, the 2·WIDTH-bit product sits on the output as A||Q, with A as the upper half.

Top module: `shift_add_mul`

## Requirements
- R1: After reset the block is idle (busy_o = 0) and product_o is all zeros.
- R2: When load_q_i is high at a clock edge in idle, Q takes data_i, so product_o[WIDTH-1:0] equals data_i after that edge. When load_b_i is high at an edge, B takes data_i.
- R3: When go_i is high at an edge in idle, busy_o is 1 after that edge.
- R4: After starting, busy_o stays 1 for exactly 2·WIDTH clock cycles and then returns to 0. The counter is loaded with WIDTH-1 at start, and its zero test is made before the decrement.
- R5: When busy_o falls, product_o equals B·Q as a full 2·WIDTH-bit unsigned value, with B and Q as they were at start.
- R6: go_i held high while busy has no effect: neither the busy length nor the product changes.
- R7: In idle, with go_i and load_q_i low, product_o holds its value, including while load_b_i writes a new B.
- R8: The add cycle is always followed by the shift cycle. An add cycle with the multiplier's low bit at 0 leaves A unchanged.
- R9: The carry out of each addition is kept in C and shifted into the top bit of A. C is cleared at start and on every shift, so all-ones operands give the full product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start request, acted on in idle only |
| load_b_i | input | 1 | Write data_i into the multiplicand register |
| load_q_i | input | 1 | Write data_i into the multiplier register |
| data_i | input | WIDTH | Operand input bus |
| product_o | output | 2·WIDTH | A concatenated with Q |
| busy_o | output | 1 | High while a multiplication runs |

## Verification
A wrong controller state shows at the ports at once as a wrong busy length. An extra or missing add/shift pair moves the fall of busy_o by two cycles. An off-by-one zero test does the same. Datapath faults show as a wrong product as soon as busy_o falls: a lost carry appears only with large operands, and a skipped add appears whenever a multiplier bit is set. An exhaustive sweep over all operand pairs at a small width exposes every such fault within a single multiplication.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  // binary state code; decoder index equals code
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_MUL0 = 2'b01,
    ST_MUL1 = 2'b10
  } mul_state_e;

  localparam int unsigned NUM_CODES = 4;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import shift_add_mul_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic zero_i,
  input  logic q0_i,
  output logic start_o,
  output logic add_o,
  output logic clear_c_o,
  output logic shift_dec_o,
  output logic idle_o
);
  logic [1:0]           state_q, state_d;
  logic [NUM_CODES-1:0] dec;

  // state decoder
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_dec
    assign dec[i] = (state_q == 2'(i));
  end

  logic st_idle, st_mul0, st_mul1;
  assign st_idle = dec[ST_IDLE];
  assign st_mul0 = dec[ST_MUL0];
  assign st_mul1 = dec[ST_MUL1];

  assign start_o     = st_idle & go_i;
  assign add_o       = st_mul0 & q0_i;
  assign clear_c_o   = start_o | st_mul1;
  assign shift_dec_o = st_mul1;
  assign idle_o      = st_idle;

  always_comb begin
    state_d[1] = st_mul0;
    state_d[0] = start_o | (st_mul1 & ~zero_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R8
  mul0_to_mul1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_mul0 |=> st_mul1);
  // R8
  unused_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(dec) && !dec[3]);
  // R4
  last_pair_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_mul1 && zero_i |=> st_idle);
  // R6
  go_busy_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_idle && go_i |=> !st_mul0 || $past(st_mul1));
endmodule

// File: rtl/mul_counter.sv
module mul_counter #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic dec_i,
  output logic zero_o
);
  localparam logic [CNT_W-1:0] P_INIT = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     p_q <= '0;
    else if (init_i) p_q <= P_INIT;
    else if (dec_i)  p_q <= p_q - 1'b1;
  end

  assign zero_o = (p_q == '0);

  // R4
  count_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> p_q == P_INIT);
  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !init_i && !zero_o |=> !zero_o || $past(p_q) == CNT_W'(1));
endmodule

// File: rtl/mul_dpath.sv
module mul_dpath #(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_b_i,
  input  logic               load_q_i,
  input  logic [WIDTH-1:0]   data_i,
  input  logic               init_i,
  input  logic               add_i,
  input  logic               clear_c_i,
  input  logic               shift_i,
  output logic               q0_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic [WIDTH-1:0] b_q, a_q, q_q;
  logic             c_q;
  logic [WIDTH:0]   sum;

  assign sum = {1'b0, a_q} + {1'b0, b_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       b_q <= '0;
    else if (load_b_i) b_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      a_q <= '0;
    else if (init_i)  a_q <= '0;
    else if (add_i)   a_q <= sum[WIDTH-1:0];
    else if (shift_i) a_q <= {c_q, a_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        c_q <= 1'b0;
    else if (clear_c_i) c_q <= 1'b0;
    else if (add_i)     c_q <= sum[WIDTH];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= '0;
    else if (load_q_i) q_q <= data_i;
    else if (shift_i)  q_q <= {a_q[0], q_q[WIDTH-1:1]};
  end

  assign q0_o      = q_q[0];
  assign product_o = {a_q, q_q};

  // R9
  carry_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_c_i |=> !c_q);
  // R9
  carry_into_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !init_i |=> a_q[WIDTH-1] == $past(c_q));
  // R8
  skip_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_i && !shift_i && !init_i |=> $stable(a_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               load_b_i,
  input  logic               load_q_i,
  input  logic [WIDTH-1:0]   data_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               busy_o
);
  logic start, add, clear_c, shift_dec, idle, zero, q0;

  mul_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_i),
    .zero_i     (zero),
    .q0_i       (q0),
    .start_o    (start),
    .add_o      (add),
    .clear_c_o  (clear_c),
    .shift_dec_o(shift_dec),
    .idle_o     (idle)
  );

  mul_counter #(.WIDTH(WIDTH)) i_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(start),
    .dec_i (shift_dec),
    .zero_o(zero)
  );

  mul_dpath #(.WIDTH(WIDTH)) i_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_b_i (load_b_i),
    .load_q_i (load_q_i),
    .data_i   (data_i),
    .init_i   (start),
    .add_i    (add),
    .clear_c_i(clear_c),
    .shift_i  (shift_dec),
    .q0_o     (q0),
    .product_o(product_o)
  );

  assign busy_o = ~idle;

  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && go_i |=> busy_o);
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !go_i && !load_q_i |=> $stable(product_o));
endmodule

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           go = 1'b0, ld_b = 1'b0, ld_q = 1'b0;
  logic [W-1:0]   din = '0;
  logic [2*W-1:0] prod;
  logic           busy;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_add_mul #(.WIDTH(W)) i_shift_add_mul (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .load_b_i(ld_b),
    .load_q_i(ld_q), .data_i(din), .product_o(prod), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic multiply(input int a, input int b, input bit poke_go);
    int cyc;
    logic [2*W-1:0] held;
    @(negedge clk); din = W'(a); ld_b = 1'b1;
    @(negedge clk); ld_b = 1'b0; din = W'(b); ld_q = 1'b1;
    @(negedge clk); ld_q = 1'b0;
    check(prod[W-1:0] == W'(b), "R2", int'(prod[W-1:0]), b);
    go = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R3", int'(busy), 1);
    go = poke_go;  // R6: go held while busy
    cyc = 0;
    while (busy && cyc <= 4*W) begin
      cyc++;
      @(negedge clk);
    end
    go = 1'b0;
    check(cyc == 2*W, "R4", cyc, 2*W);
    if (a == (1<<W)-1 && b == (1<<W)-1)
      check(int'(prod) == a*b, "R9", int'(prod), a*b);
    else
      check(int'(prod) == a*b, poke_go ? "R6" : "R5", int'(prod), a*b);
    // R7: B rewrite in idle must leave product alone
    held = prod;
    din = ~W'(a); ld_b = 1'b1;
    @(negedge clk); ld_b = 1'b0;
    @(negedge clk);
    check(prod == held && !busy, "R7", int'(prod), int'(held));
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(busy == 1'b0, "R1", int'(busy), 0);
    check(prod == '0, "R1", int'(prod), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && prod == '0, "R1", int'(prod), 0);
    // R8: zero multiplier skips every add; R9: all-ones needs carry
    multiply((1<<W)-1, 0, 1'b0);
    multiply((1<<W)-1, (1<<W)-1, 1'b0);
    multiply(1, (1<<W)-1, 1'b1);
    for (int a = 0; a < (1<<W); a++) begin
      for (int b = 0; b < (1<<W); b++) begin
        multiply(a, b, ((a + b) % 3) == 0);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule